// File: doc/BRIEF.md
# Multichannel Sample Packer

The packer gathers samples from a set of parallel channel ports and writes only the channels that are switched on into a dense output word. Every channel port is qualified by one shared input strobe. A per-channel enable mask selects which channels take part. The selected samples are written into an internal holding buffer. As soon as the buffer holds enough samples to fill one output word, the word is pushed out on a single write-only port, with a one-cycle strobe.

The output has no ready signal. The consumer must take every word in the cycle its strobe is high. The block is meant to sit between a multi-channel sample source and a wide FIFO or DMA path, where channel selection is a runtime choice.

Control is a two-state machine that follows the holding buffer:

- **ST_EMPTY**: no samples are held.
- **ST_PARTIAL**: between one and NUM_CH-1 samples are held.

The transitions are:

- **T_START** (ST_EMPTY to ST_PARTIAL): a beat leaves samples behind.
- **T_ALIGN** (ST_PARTIAL to ST_EMPTY): a beat ends exactly on a word boundary.
- **T_STAY**: any other beat, or an idle cycle, keeps the current state.

Top module: `sample_packer`

## Requirements
- R1: When `in_wr` is low, no sample is taken, no word is emitted in the next cycle, and the held samples are left unchanged, whatever is on `in_data` and `in_en`.
- R2: A channel whose `in_en` bit is 0 adds nothing to the output. A beat with every bit of `in_en` at 0 emits nothing and leaves the buffer fill unchanged.
- R3: Output slot i occupies bits [i*SAMPLE_W +: SAMPLE_W] of `out_data`, with slot 0 in the least significant bits. Within a beat, samples go to ascending slots in ascending channel order. Samples from an earlier beat sit in lower slots than samples from a later beat.
- R4: `out_wr` is high for exactly one cycle per word: the cycle after the input beat that completes the word. It is low in every other cycle. No input exists to stall it.
- R5: With all NUM_CH channels enabled, every beat produces one word, in the following cycle.
- R6: With k enabled channels, k a power of two, one word is produced every NUM_CH/k beats.
- R7: With any other number of enabled channels, a beat's samples may straddle two words. Samples beyond the word boundary are held and become the lowest slots of the next word.
- R8: A synchronous reset empties the buffer and clears the fill count. `out_wr` is low during reset, and it stays low afterwards until a full word has been collected from beats after the reset.
- R9: `in_en` may change between beats. Samples already held are kept, and the new mask applies from the beat where it is presented.
- R10: The state returns to ST_EMPTY when a beat completes a word with nothing left over. The next word then starts at slot 0 with the next beat's samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_wr | input | 1 | Shared strobe qualifying all channel ports this cycle |
| in_en | input | NUM_CH | Per-channel enable, bit i for channel i |
| in_data | input | NUM_CH*SAMPLE_W | Channel i sample at bits [i*SAMPLE_W +: SAMPLE_W] |
| out_wr | output | 1 | One-cycle strobe marking a complete output word |
| out_data | output | NUM_CH*SAMPLE_W | Packed word, valid only while `out_wr` is high |

## Verification
The assertions take for granted that `rst` is asserted at the first clock edge, and that `in_wr`, `in_en` and `in_data` are known values whenever reset is low. The stimulus keeps to this by holding reset for several cycles at start-up. It drives every input to a defined value, changing them only on the falling edge.

The stimulus sweeps every enable mask. Between beats it inserts idle cycles that carry changing, meaningless data. It also changes the mask while samples are still held, to exercise the carried residue and the mid-fill mask switch.

// File: rtl/sample_pack_pkg.sv
package sample_pack_pkg;

    typedef enum logic [0:0] {
        ST_EMPTY   = 1'b0,
        ST_PARTIAL = 1'b1
    } fill_state_e;

endpackage

// File: rtl/sp_compact.sv
module sp_compact #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16,
    localparam int WORD_W  = NUM_CH * SAMPLE_W,
    localparam int CNT_W   = $clog2(NUM_CH) + 1
) (
    input  logic [NUM_CH-1:0] en,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] dense,
    output logic [CNT_W-1:0]  count
);

    // Enabled samples are moved down to consecutive low slots, in channel order.
    always_comb begin
        int pos;
        pos   = 0;
        dense = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (en[i]) begin
                dense[pos*SAMPLE_W +: SAMPLE_W] = data[i*SAMPLE_W +: SAMPLE_W];
                pos = pos + 1;
            end
        end
        count = CNT_W'(pos);
    end

endmodule

// File: rtl/sp_accum.sv
module sp_accum
    import sample_pack_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16,
    localparam int WORD_W  = NUM_CH * SAMPLE_W,
    localparam int FILL_W  = $clog2(NUM_CH),
    localparam int CNT_W   = FILL_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat,
    input  logic [WORD_W-1:0] slots,
    input  logic [CNT_W-1:0]  count,
    output logic              out_wr,
    output logic [WORD_W-1:0] out_data
);

    fill_state_e         state_q, state_d;
    logic [FILL_W-1:0]   fill_q, fill_d, base_fill;
    logic [WORD_W-1:0]   hold_q, hold_d;
    logic [2*WORD_W-1:0] merged;
    logic [CNT_W-1:0]    total;
    logic                wrap;

    // In ST_EMPTY the held contents are ignored completely.
    assign base_fill = (state_q == ST_EMPTY) ? '0 : fill_q;

    // Held samples stay in their slots; new samples go in just above them.
    always_comb begin
        merged = '0;
        for (int j = 0; j < 2*NUM_CH; j++) begin
            if (j < int'(base_fill)) begin
                merged[j*SAMPLE_W +: SAMPLE_W] = hold_q[j*SAMPLE_W +: SAMPLE_W];
            end else if ((j - int'(base_fill)) < NUM_CH) begin
                merged[j*SAMPLE_W +: SAMPLE_W] =
                    slots[(j - int'(base_fill))*SAMPLE_W +: SAMPLE_W];
            end
        end
    end

    assign total = CNT_W'(base_fill) + count;
    assign wrap  = int'(total) >= NUM_CH;

    always_comb begin
        fill_d = fill_q;
        hold_d = hold_q;
        if (beat) begin
            if (wrap) begin
                fill_d = FILL_W'(int'(total) - NUM_CH);
                hold_d = merged[2*WORD_W-1:WORD_W];
            end else begin
                fill_d = FILL_W'(total);
                hold_d = merged[WORD_W-1:0];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:   if (beat && fill_d != '0) state_d = ST_PARTIAL; // T_START
            ST_PARTIAL: if (beat && fill_d == '0) state_d = ST_EMPTY;   // T_ALIGN
            default:    state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    // Buffer and fill count
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            hold_q <= '0;
        end else begin
            fill_q <= fill_d;
            hold_q <= hold_d;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            out_wr   <= 1'b0;
            out_data <= '0;
        end else begin
            out_wr <= beat && wrap;
            if (beat && wrap) out_data <= merged[WORD_W-1:0];
        end
    end

    AST_IDLE_NO_EMIT: assert property (@(posedge clk) disable iff (rst)
        !beat |=> !out_wr); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !beat |=> ($stable(fill_q) && $stable(hold_q))); // R1
    AST_MASKED_OUT: assert property (@(posedge clk) disable iff (rst)
        (beat && count == '0) |=> (!out_wr && $stable(fill_q))); // R2
    AST_EMIT_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> $past(beat)); // R4
    AST_FULL_EVERY_BEAT: assert property (@(posedge clk) disable iff (rst)
        (beat && int'(count) == NUM_CH) |=> out_wr); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_wr && fill_q == '0)); // R8
    AST_STATE_TRACKS_FILL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMPTY) == (fill_q == '0)); // R10

endmodule

// File: rtl/sample_packer.sv
module sample_packer #(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 16,
    localparam int WORD_W  = NUM_CH * SAMPLE_W,
    localparam int CNT_W   = $clog2(NUM_CH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_wr,
    input  logic [NUM_CH-1:0] in_en,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_wr,
    output logic [WORD_W-1:0] out_data
);

    generate
        if (NUM_CH < 2 || NUM_CH > 64 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_cfg
            $error("sample_packer: NUM_CH must be a power of two from 2 to 64");
        end
    endgenerate

    logic [WORD_W-1:0] dense;
    logic [CNT_W-1:0]  count;

    sp_compact #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_compact (
        .en    (in_en),
        .data  (in_data),
        .dense (dense),
        .count (count)
    );

    sp_accum #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_accum (
        .clk      (clk),
        .rst      (rst),
        .beat     (in_wr),
        .slots    (dense),
        .count    (count),
        .out_wr   (out_wr),
        .out_data (out_data)
    );

endmodule

// File: tb/tb_sample_packer.sv
`timescale 1ns/1ps
module tb_sample_packer;

    localparam int N  = 4;
    localparam int SW = 16;
    localparam int W  = N * SW;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_wr = 1'b0;
    logic [N-1:0] in_en = '0;
    logic [W-1:0] in_data = '0;
    logic         out_wr;
    logic [W-1:0] out_data;

    always #2 clk = ~clk;

    sample_packer #(.NUM_CH(N), .SAMPLE_W(SW)) dut (
        .clk(clk), .rst(rst), .in_wr(in_wr), .in_en(in_en), .in_data(in_data),
        .out_wr(out_wr), .out_data(out_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int word_cnt = 0;
    logic [W-1:0] last_word = '0;
    logic [SW-1:0] ref_q[$];
    logic exp_wr = 1'b0;
    logic [W-1:0] exp_word = '0;
    bit done = 0;

    // Reference model: a queue of enabled samples, drained one word at a time
    always @(posedge clk) begin
        if (rst) begin
            ref_q.delete();
            exp_wr = 1'b0;
        end else begin
            if (in_wr)
                for (int i = 0; i < N; i++)
                    if (in_en[i]) ref_q.push_back(in_data[i*SW +: SW]);
            if (ref_q.size() >= N) begin
                exp_wr = 1'b1;
                for (int i = 0; i < N; i++) exp_word[i*SW +: SW] = ref_q.pop_front();
            end else begin
                exp_wr = 1'b0;
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (out_wr !== exp_wr) begin
                n_bad++;
                $display("FAIL R4 strobe at %0t: got %b expected %b", $time, out_wr, exp_wr);
            end else if (out_wr) begin
                n_cmp++;
                if (out_data !== exp_word) begin
                    n_bad++;
                    $display("FAIL R3 word at %0t: got %h expected %h", $time, out_data, exp_word);
                end
            end
            if (out_wr === 1'b1) begin
                word_cnt++;
                last_word = out_data;
            end
        end
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [N-1:0] m, input logic [W-1:0] d);
        @(negedge clk);
        in_wr = wr; in_en = m; in_data = d;
    endtask

    task automatic idle();
        drive(1'b0, N'($urandom()), W'({$urandom(), $urandom()}));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 strobe low in reset", W'(out_wr), '0);
        rst = 1'b0;
    endtask

    function automatic logic [SW-1:0] s(input logic [W-1:0] d, input int i);
        return d[i*SW +: SW];
    endfunction

    initial begin
        logic [W-1:0] a, b, c;
        repeat (3) @(negedge clk);
        chk("R8 reset state", W'(out_wr), '0);
        rst = 1'b0;

        // Sweep every mask; 2*N beats yield 2*popcount words
        for (int m = 0; m < (1 << N); m++) begin
            int k;
            string tag;
            k = $countones(N'(m));
            do_reset();
            word_cnt = 0;
            for (int bt = 0; bt < 2*N; bt++) begin
                drive(1'b1, N'(m), W'({$urandom(), $urandom()}));
                if (bt % 3 == 1) idle(); // R1 gaps with junk data
            end
            idle(); idle();
            if (k == 0)                tag = "R2 zero mask word count";
            else if (k == N)           tag = "R5 full mask word count";
            else if ((k & (k-1)) == 0) tag = "R6 pow2 mask word count";
            else                       tag = "R7 odd mask word count";
            chk(tag, W'(word_cnt), W'(2*k));
        end

        // R7: straddle, residue becomes low slots of the next word
        do_reset();
        a = W'({$urandom(), $urandom()}); b = W'({$urandom(), $urandom()});
        c = W'({$urandom(), $urandom()});
        drive(1'b1, 4'b0111, a); drive(1'b1, 4'b0111, b); idle(); idle();
        chk("R7 first straddled word", last_word, {s(b,0), s(a,2), s(a,1), s(a,0)});
        drive(1'b1, 4'b0011, c); idle(); idle();
        chk("R7 residue word", last_word, {s(c,1), s(c,0), s(b,2), s(b,1)});

        // R9: mask change while samples held
        do_reset();
        a = W'({$urandom(), $urandom()}); b = W'({$urandom(), $urandom()});
        drive(1'b1, 4'b0001, a); idle();
        drive(1'b1, 4'b0111, b); idle(); idle();
        chk("R9 mask switch word", last_word, {s(b,2), s(b,1), s(b,0), s(a,0)});

        // R8: reset mid-fill discards held samples
        do_reset();
        drive(1'b1, 4'b0011, W'({$urandom(), $urandom()}));
        do_reset();
        a = W'({$urandom(), $urandom()}); b = W'({$urandom(), $urandom()});
        word_cnt = 0;
        drive(1'b1, 4'b0011, a); idle(); idle();
        chk("R8 no word from half fill", W'(word_cnt), '0);
        drive(1'b1, 4'b0011, b); idle(); idle();
        chk("R8 word after reset", last_word, {s(b,1), s(b,0), s(a,1), s(a,0)});

        // R10: aligned completion returns to empty; next word starts at slot 0
        c = W'({$urandom(), $urandom()});
        drive(1'b1, 4'b1111, c); idle(); idle();
        chk("R10 aligned restart", last_word, c);

        // R1: idle cycles with junk leave the buffer alone
        do_reset();
        a = W'({$urandom(), $urandom()}); b = W'({$urandom(), $urandom()});
        drive(1'b1, 4'b0011, a);
        repeat (5) idle();
        drive(1'b1, 4'b0011, b); idle(); idle();
        chk("R1 idle ignored", last_word, {s(b,1), s(b,0), s(a,1), s(a,0)});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule